// File: doc/BRIEF.md
# Receive Timestamp and Sticky Status Generator

This block produces the 16-bit stamp that the receive path stores in the first word of each finished cell buffer, right before the head pointer moves on. The stamp carries the current frame number, a tag saying where the cell came from, two of the latched error flags, and a marker in the top bit that is always set. Because of that marker, a stamped buffer handed to a host request can also serve as a marked header word.

The frame number comes from a small two-state sequencer. In `FT_COUNT` it steps a prescaler. On the cycle the prescaler reaches `FRAME_LEN-2` it takes the transition `count_done` into `FT_PULSE`. `FT_PULSE` lasts one cycle: it raises the frame pulse, advances the 11-bit frame counter and takes the transition `pulse_done` back to `FT_COUNT`. Reset enters `FT_COUNT` with the prescaler and the counter at zero.

The same block keeps a sticky three-bit status register fed by error event pulses. Once a bit is set it stays set until the processor issues a read-and-clear strobe.

Top module: `rx_stamp_gen`

## Requirements
- R1: Stamp bits 10:0 hold a frame counter that rises by exactly one per frame pulse and holds its value otherwise.
- R2: With the default `FRAME_LEN` of 64, the counter reads 0 for the first 63 clock edges after reset release and reads 1 after edge 64. After that it rises every 64 edges.
- R3: The frame counter wraps from 2047 to 0.
- R4: Stamp bits 12:11 follow `cell_src` in the same cycle. The encodings are 00 for a host request, 01 for the receive FIFO and 10 for the loopback FIFO.
- R5: Stamp bit 15 is 1 in every cycle, including during reset.
- R6: Stamp bit 14 equals the latched stray-bytes flag and stamp bit 13 equals the latched timeout flag.
- R7: An event pulse sets its status bit from the next cycle onward. The bits are timeout at bit 0, stray bytes at bit 1 and discard at bit 2. A set bit stays set until a read-and-clear.
- R8: A discard event also sets the stray-bytes bit.
- R9: A read-and-clear strobe with no event in the same cycle makes every status bit read 0 from the next cycle.
- R10: An event that arrives in the same cycle as a read-and-clear is latched and reads 1 afterwards. The other bits are cleared.
- R11: While reset is held, the counter and status read 0, so the stamp is `16'h8000` with `cell_src` at 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_src | input | 2 | Source tag of the cell currently being received |
| ev_timeout | input | 1 | Cell timeout event pulse |
| ev_stray | input | 1 | Stray bytes event pulse |
| ev_discard | input | 1 | Cell discarded event pulse |
| stat_rd_clr | input | 1 | Processor status read-and-clear strobe |
| ts_word | output | 16 | Timestamp word for buffer word 0 |
| stat_q | output | 3 | Sticky status register |

## Verification
Two things can land in the same cycle: a read-and-clear strobe and a fresh error event. The bench provokes this by raising `stat_rd_clr` together with a single event. It then checks that the event's bit survives while the others clear, and it also checks the case where a discard lands on a clear and must set both discard and stray bytes. A frame pulse can also fall in a cycle where the status changes. The cycle-by-cycle reference model compares every stamp field on every clock, so the bench judges that overlap throughout the full counter wrap.

// File: rtl/rx_stamp_pkg.sv
package rx_stamp_pkg;

    typedef enum logic [0:0] {
        FT_COUNT = 1'b0,
        FT_PULSE = 1'b1
    } ft_state_e;

    localparam logic [1:0] SRC_HOST     = 2'b00;
    localparam logic [1:0] SRC_RX_FIFO  = 2'b01;
    localparam logic [1:0] SRC_LOOPBACK = 2'b10;

    localparam int ST_W       = 3;
    localparam int ST_TIMEOUT = 0;
    localparam int ST_STRAY   = 1;
    localparam int ST_DISCARD = 2;

    localparam int WORD_W = 16;

endpackage

// File: rtl/frame_timer.sv
module frame_timer
    import rx_stamp_pkg::*;
#(
    parameter int FRAME_LEN = 64,
    parameter int CTR_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             frame_pulse,
    output logic [CTR_W-1:0] frame_ctr
);

    localparam int PW = $clog2(FRAME_LEN);
    localparam logic [PW-1:0] LAST_COUNT = PW'(FRAME_LEN - 2);

    ft_state_e     state_q, state_d;
    logic [PW-1:0] pre_q,   pre_d;
    logic [CTR_W-1:0] ctr_q, ctr_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FT_COUNT;
            pre_q   <= '0;
            ctr_q   <= '0;
        end else begin
            state_q <= state_d;
            pre_q   <= pre_d;
            ctr_q   <= ctr_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        pre_d       = pre_q;
        ctr_d       = ctr_q;
        frame_pulse = 1'b0;
        unique case (state_q)
            FT_COUNT: begin
                pre_d = pre_q + 1'b1;
                if (pre_q == LAST_COUNT) begin
                    state_d = FT_PULSE;       // count_done
                end
            end
            FT_PULSE: begin
                frame_pulse = 1'b1;
                pre_d       = '0;
                ctr_d       = ctr_q + 1'b1;   // wraps at 2**CTR_W
                state_d     = FT_COUNT;       // pulse_done
            end
        endcase
    end

    assign frame_ctr = ctr_q;

    p_ctr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> $stable(frame_ctr));

    p_ctr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (frame_ctr == CTR_W'($past(frame_ctr) + 1'b1)));

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> !frame_pulse);

endmodule

// File: rtl/status_latch.sv
module status_latch
    import rx_stamp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_timeout,
    input  logic            ev_stray,
    input  logic            ev_discard,
    input  logic            rd_clr,
    output logic [ST_W-1:0] stat_q
);

    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] stat_d;

    always_comb begin
        set_vec              = '0;
        set_vec[ST_TIMEOUT]  = ev_timeout;
        set_vec[ST_STRAY]    = ev_stray | ev_discard;
        set_vec[ST_DISCARD]  = ev_discard;
        stat_d               = (rd_clr ? '0 : stat_q) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && stat_q[ST_TIMEOUT]) |=> stat_q[ST_TIMEOUT]);

    p_discard_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_discard |=> (stat_q[ST_STRAY] && stat_q[ST_DISCARD]));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !ev_timeout && !ev_stray && !ev_discard) |=> (stat_q == '0));

    p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ev_timeout) |=> stat_q[ST_TIMEOUT]);

endmodule

// File: rtl/rx_stamp_gen.sv
module rx_stamp_gen
    import rx_stamp_pkg::*;
#(
    parameter int FRAME_LEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cell_src,
    input  logic        ev_timeout,
    input  logic        ev_stray,
    input  logic        ev_discard,
    input  logic        stat_rd_clr,
    output logic [15:0] ts_word,
    output logic [2:0]  stat_q
);

    localparam int CTR_W = 11;

    logic             frame_pulse;
    logic [CTR_W-1:0] frame_ctr;
    logic [ST_W-1:0]  stat_int;

    frame_timer #(
        .FRAME_LEN (FRAME_LEN),
        .CTR_W     (CTR_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .frame_ctr   (frame_ctr)
    );

    status_latch u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_timeout (ev_timeout),
        .ev_stray   (ev_stray),
        .ev_discard (ev_discard),
        .rd_clr     (stat_rd_clr),
        .stat_q     (stat_int)
    );

    assign ts_word = {1'b1, stat_int[ST_STRAY], stat_int[ST_TIMEOUT], cell_src, frame_ctr};
    assign stat_q  = stat_int;

    p_word_ctr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (ts_word[10:0] != $past(ts_word[10:0])));

    p_word_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stray |=> ts_word[14]);

endmodule

// File: tb/rx_stamp_gen_bench.sv
`timescale 1ns/1ps
module rx_stamp_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cell_src = 2'b00;
    logic        ev_timeout = 1'b0;
    logic        ev_stray = 1'b0;
    logic        ev_discard = 1'b0;
    logic        stat_rd_clr = 1'b0;
    logic [15:0] ts_word;
    logic [2:0]  stat_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit run_model_cmp = 1'b0;

    // reference model state
    int m_pre = 0;
    int m_ctr = 0;
    int m_st  = 0;

    always #2.5 clk = ~clk;

    rx_stamp_gen u_rx_stamp_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cell_src    (cell_src),
        .ev_timeout  (ev_timeout),
        .ev_stray    (ev_stray),
        .ev_discard  (ev_discard),
        .stat_rd_clr (stat_rd_clr),
        .ts_word     (ts_word),
        .stat_q      (stat_q)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_ctr = 0; m_st = 0;
        end else begin
            int nxt;
            if (m_pre == 63) begin
                m_pre = 0;
                m_ctr = (m_ctr + 1) % 2048;
            end else begin
                m_pre = m_pre + 1;
            end
            nxt = stat_rd_clr ? 0 : m_st;
            if (ev_timeout) nxt = nxt | 1;
            if (ev_stray)   nxt = nxt | 2;
            if (ev_discard) nxt = nxt | 6;
            m_st = nxt;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (run_model_cmp && rst_n) begin
            chk(int'(ts_word[10:0]),  m_ctr,                 "R1 counter field");
            chk(int'(ts_word[12:11]), int'(cell_src),        "R4 source field");
            chk(int'(ts_word[15]),    1,                     "R5 marker bit");
            chk(int'(ts_word[14:13]), (m_st >> 1 & 1) * 2 + (m_st & 1), "R6 status flags in word");
            chk(int'(stat_q),         m_st,                  "R7 status register");
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ev(input bit t, input bit s, input bit d, input bit c);
        ev_timeout = t; ev_stray = s; ev_discard = d; stat_rd_clr = c;
        @(negedge clk);
        ev_timeout = 0; ev_stray = 0; ev_discard = 0; stat_rd_clr = 0;
    endtask

    initial begin
        // R11 reset state
        idle(3);
        chk(int'(ts_word), 16'h8000, "R11 reset stamp");
        chk(int'(stat_q), 0, "R11 reset status");
        rst_n = 1'b1;
        // R2 first increment timing: 63 edges then 64
        idle(63);
        chk(int'(ts_word[10:0]), 0, "R2 count after 63 edges");
        idle(1);
        chk(int'(ts_word[10:0]), 1, "R2 count after 64 edges");
        idle(64);
        chk(int'(ts_word[10:0]), 2, "R2 count after 128 edges");
        run_model_cmp = 1'b1;

        // R4 source encodings
        cell_src = 2'b01; @(negedge clk);
        chk(int'(ts_word[12:11]), 1, "R4 rx fifo tag");
        cell_src = 2'b10; @(negedge clk);
        chk(int'(ts_word[12:11]), 2, "R4 loopback tag");
        cell_src = 2'b00;

        // R7 timeout sticky
        pulse_ev(1, 0, 0, 0);
        chk(int'(stat_q), 1, "R7 timeout set");
        idle(5);
        chk(int'(stat_q), 1, "R7 timeout held");
        chk(int'(ts_word[13]), 1, "R6 timeout in word");
        // R9 clear
        pulse_ev(0, 0, 0, 1);
        chk(int'(stat_q), 0, "R9 cleared");
        // R8 discard implies stray
        pulse_ev(0, 0, 1, 0);
        chk(int'(stat_q), 6, "R8 discard sets stray");
        chk(int'(ts_word[14]), 1, "R6 stray in word");
        // R10 event collides with clear
        pulse_ev(1, 0, 0, 1);
        chk(int'(stat_q), 1, "R10 timeout kept on clear");
        pulse_ev(0, 0, 1, 1);
        chk(int'(stat_q), 6, "R10 discard kept on clear");
        pulse_ev(0, 1, 0, 0);
        chk(int'(stat_q), 6, "R7 stray set again");
        pulse_ev(0, 0, 0, 1);
        chk(int'(stat_q), 0, "R9 cleared again");

        // long run with scattered stimulus up to the wrap
        while (m_ctr != 2047) begin
            cell_src    = 2'($urandom_range(0, 2));
            ev_timeout  = ($urandom_range(0, 99) == 0);
            ev_stray    = ($urandom_range(0, 99) == 0);
            ev_discard  = ($urandom_range(0, 149) == 0);
            stat_rd_clr = ($urandom_range(0, 39) == 0);
            @(negedge clk);
        end
        ev_timeout = 0; ev_stray = 0; ev_discard = 0; stat_rd_clr = 0;
        while (m_ctr != 0) @(negedge clk);
        chk(int'(ts_word[10:0]), 0, "R3 wrap to zero");
        idle(64);
        chk(int'(ts_word[10:0]), 1, "R3 count after wrap");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule